// File: doc/BRIEF.md
# Multiplexed Address and Visibility Bus Driver

This block turns a stream of internal bus accesses into the pin activity of a time-multiplexed external address bus. Every bus cycle has two phases of a 2x clock. In the high phase the address pins carry the access address. In the low phase the same pins carry three things: the access code of the current access, the instruction-queue status of the previous bus cycle, and a lane-steered copy of the previous access's internal read data. An external tracer can therefore reconstruct internal reads that never appear on the data pins.

Access descriptors arrive over a valid/ready interface. `acc_ready` is high only during the low phase of the running bus cycle, and a descriptor is taken at the edge that ends that phase. A producer that has nothing to send leaves `acc_valid` low. The block then runs an idle bus cycle and does not stall. A descriptor that is offered during a high phase waits, held steady by the producer, until the next low phase. Internal read data (`int_rdata`) must be valid during the high phase of its own access. Bits 15:8 hold the byte at the access address and bits 7:0 hold the byte at address+1. A byte read returns its byte in bits 15:8.

Top module: `mvb_bus_driver`

## Requirements
- R1: While reset is asserted, `bus_addr` is 0, `bus_rw` is 1, `bus_data_oe` is 0, `eclk` is 0 and `acc_ready` is 1.
- R2: `eclk` alternates every clock. `acc_ready` is high only when `eclk` is low. If no descriptor is valid at an accepting edge, the following bus cycle is idle: address 0, access code 0, queue status 0 and `bus_rw` 1.
- R3: In the clock cycle after an accepted descriptor, `eclk` is 1 and `bus_addr` equals the accepted address.
- R4: In the low phase of an access, `bus_addr[22:20]` carries that access's 3-bit code.
- R5: In the low phase, `bus_addr[19:16]` carries the queue status of the previous bus cycle.
- R6: In the low phase, `bus_addr[15:0]` carries visibility data of the previous bus cycle. For an internal aligned word read it is {byte at even address, byte at even+1}.
- R7: For an internal word read at an odd address, the visibility word is {byte at odd+1, byte at odd}.
- R8: For an internal byte read at an even address, the visibility word is {the byte, address bits 7:0}.
- R9: For an internal byte read at an odd address, the visibility word is {address bits 15:8, the byte}.
- R10: After a write, an external read or an idle cycle, the visibility word is 0. The first low phase after reset shows 0.
- R11: `bus_rw` is 0 throughout a write access and 1 otherwise. `bus_data_oe` is high, and `bus_data_o` equals the write data, only in the low phase of a write. On reads the data pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x internal clock, one edge per bus phase |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Descriptor valid |
| acc_ready | output | 1 | Descriptor accepted at the next edge when high |
| acc_addr | input | 23 | Access address |
| acc_word | input | 1 | 1 word access, 0 byte access |
| acc_rd | input | 1 | 1 read, 0 write |
| acc_ext | input | 1 | 1 external target, 0 internal |
| acc_code | input | 3 | Access code shown in low phase |
| acc_qst | input | 4 | Instruction-queue status of this cycle |
| acc_wdata | input | 16 | Write data |
| int_rdata | input | 16 | Internal read data, valid in the access's high phase |
| eclk | output | 1 | Bus phase, 1 = high (address) phase |
| bus_addr | output | 23 | Multiplexed address / status / visibility pins |
| bus_data_o | output | 16 | Data pins output value |
| bus_data_oe | output | 1 | Data pins output enable |
| bus_rw | output | 1 | 1 read or idle, 0 write |

## Verification
The assertions check the following on every cycle: the phase alternation, that ready appears only in the low phase, that the accepted address appears on the next edge, that the access code appears two edges after acceptance, and that the data driver is enabled only during the low phase of a write. The scenarios alone can show the one-access lag of the queue status and the visibility data, since these carry state across bus cycles. The same holds for the four lane-steering cases and for zeroing after writes, external reads and idles. The bench runs mixed back-to-back sequences with a scoreboard model for these.

// File: rtl/mvb_pkg.sv
package mvb_pkg;
  localparam int CODE_W = 3;
  localparam int QST_W  = 4;
  localparam int VIS_W  = 16;
  localparam int ADDR_W = CODE_W + QST_W + VIS_W;
  localparam int BYTE_W = VIS_W / 2;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic              word;
    logic              rd;
    logic              ext;
    logic [CODE_W-1:0] code;
    logic [QST_W-1:0]  qst;
    logic [VIS_W-1:0]  wdata;
  } acc_t;
endpackage

// File: rtl/mvb_phase.sv
module mvb_phase (
  input  logic clk,
  input  logic rst_n,
  output logic ph_high
);
  always_ff @(posedge clk) begin
    if (!rst_n) ph_high <= 1'b0;
    else        ph_high <= ~ph_high;
  end
endmodule

// File: rtl/mvb_steer.sv
module mvb_steer #(
  parameter int VIS_W = 16
) (
  input  logic [VIS_W-1:0] lo_addr,
  input  logic             vld,
  input  logic             word,
  input  logic             rd,
  input  logic             ext,
  input  logic [VIS_W-1:0] rdata,
  output logic [VIS_W-1:0] vis
);
  localparam int BW = VIS_W / 2;
  logic [BW-1:0] b_at, b_nxt;
  assign b_at  = rdata[VIS_W-1:BW];
  assign b_nxt = rdata[BW-1:0];

  always_comb begin
    if (!vld || !rd || ext)  vis = '0;
    else if (word) begin
      if (lo_addr[0])        vis = {b_nxt, b_at};
      else                   vis = {b_at, b_nxt};
    end else begin
      if (lo_addr[0])        vis = {lo_addr[VIS_W-1:BW], b_at};
      else                   vis = {b_at, lo_addr[BW-1:0]};
    end
  end
endmodule

// File: rtl/mvb_bus_driver.sv
module mvb_bus_driver
  import mvb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_word,
  input  logic              acc_rd,
  input  logic              acc_ext,
  input  logic [CODE_W-1:0] acc_code,
  input  logic [QST_W-1:0]  acc_qst,
  input  logic [VIS_W-1:0]  acc_wdata,
  input  logic [VIS_W-1:0]  int_rdata,
  output logic              eclk,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [VIS_W-1:0]  bus_data_o,
  output logic              bus_data_oe,
  output logic              bus_rw
);
  logic ph_high;
  mvb_phase u_phase (.clk(clk), .rst_n(rst_n), .ph_high(ph_high));

  assign acc_ready = ~ph_high;
  assign eclk      = ph_high;

  acc_t nxt, cur;
  always_comb begin
    nxt = '0;
    if (acc_valid) begin
      nxt.vld   = 1'b1;
      nxt.addr  = acc_addr;
      nxt.word  = acc_word;
      nxt.rd    = acc_rd;
      nxt.ext   = acc_ext;
      nxt.code  = acc_code;
      nxt.qst   = acc_qst;
      nxt.wdata = acc_wdata;
    end
  end

  logic [VIS_W-1:0] vis_calc, vis_pend, vis_hold;
  logic [QST_W-1:0] qst_hold;
  logic             cur_wr;
  assign cur_wr = cur.vld & ~cur.rd;

  mvb_steer #(.VIS_W(VIS_W)) u_steer (
    .lo_addr(cur.addr[VIS_W-1:0]), .vld(cur.vld), .word(cur.word),
    .rd(cur.rd), .ext(cur.ext), .rdata(int_rdata), .vis(vis_calc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur         <= '0;
      vis_pend    <= '0;
      vis_hold    <= '0;
      qst_hold    <= '0;
      bus_addr    <= '0;
      bus_rw      <= 1'b1;
      bus_data_oe <= 1'b0;
      bus_data_o  <= '0;
    end else if (!ph_high) begin
      cur         <= nxt;
      qst_hold    <= cur.qst;
      vis_hold    <= vis_pend;
      bus_addr    <= nxt.addr;
      bus_rw      <= ~(nxt.vld & ~nxt.rd);
      bus_data_oe <= 1'b0;
      bus_data_o  <= '0;
    end else begin
      vis_pend    <= vis_calc;
      bus_addr    <= {cur.code, qst_hold, vis_hold};
      bus_data_oe <= cur_wr;
      bus_data_o  <= cur_wr ? cur.wdata : '0;
    end
  end

  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    eclk |=> !eclk);
  a_r2_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && !acc_valid) |=> (bus_addr == '0 && bus_rw));
  a_r3_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid) |=> (eclk && bus_addr == $past(acc_addr)));
  a_r4_low_code: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid) |=> ##1
      (bus_addr[ADDR_W-1 -: CODE_W] == $past(acc_code, 2)));
  a_r11_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!eclk && !bus_rw));
endmodule

// File: tb/mvb_bus_driver_test.sv
module mvb_bus_driver_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_word = 0, acc_rd = 1, acc_ext = 0;
  logic [22:0] acc_addr = '0;
  logic [2:0]  acc_code = '0;
  logic [3:0]  acc_qst = '0;
  logic [15:0] acc_wdata = '0, int_rdata = '0;
  logic acc_ready, eclk, bus_data_oe, bus_rw;
  logic [22:0] bus_addr;
  logic [15:0] bus_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvb_bus_driver uut (.*);

  typedef struct {
    logic [22:0] hi; logic [22:0] lo; logic rw; logic oe; logic [15:0] dout;
    string htag; string vtag;
  } item_t;
  item_t sb[$];

  int vectors = 0, fails = 0;
  logic [3:0]  pq = '0;
  logic [15:0] pv = '0;
  string ptag = "R10";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit v, logic [22:0] a, bit w, bit rd, bit ex,
                       logic [2:0] c, logic [3:0] q, logic [15:0] wd, logic [15:0] rdd);
    item_t it;
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    chk("R2 ready in low phase", eclk, 0);
    acc_valid = v; acc_addr = a; acc_word = w; acc_rd = rd; acc_ext = ex;
    acc_code = c; acc_qst = q; acc_wdata = wd; int_rdata = rdd;
    it.hi   = v ? a : '0;
    it.lo   = {v ? c : 3'd0, pq, pv};
    it.rw   = !(v && !rd);
    it.oe   = v && !rd;
    it.dout = (v && !rd) ? wd : '0;
    it.htag = v ? "R3" : "R2";
    it.vtag = ptag;
    sb.push_back(it);
    pq = v ? q : 4'd0;
    if (!v || !rd || ex) begin pv = '0; ptag = "R10"; end
    else if (w) begin
      if (a[0]) begin pv = {rdd[7:0], rdd[15:8]}; ptag = "R7"; end
      else      begin pv = rdd;                   ptag = "R6"; end
    end else begin
      if (a[0]) begin pv = {a[15:8], rdd[15:8]}; ptag = "R9"; end
      else      begin pv = {rdd[15:8], a[7:0]};  ptag = "R8"; end
    end
    @(posedge clk);
  endtask

  item_t cur_it;
  bit have = 0;
  always @(negedge clk) begin
    if (!rst_n) have = 0;
    else if (eclk) begin
      if (sb.size() > 0) begin
        cur_it = sb.pop_front();
        chk({cur_it.htag, " high addr"}, bus_addr, cur_it.hi);
        chk("R11 rw high phase", bus_rw, cur_it.rw);
        chk("R11 oe high phase", bus_data_oe, 0);
        have = 1;
      end
    end else if (have) begin
      chk("R4 code", bus_addr[22:20], cur_it.lo[22:20]);
      chk("R5 qstat", bus_addr[19:16], cur_it.lo[19:16]);
      chk({cur_it.vtag, " visibility"}, bus_addr[15:0], cur_it.lo[15:0]);
      chk("R11 rw low phase", bus_rw, cur_it.rw);
      chk("R11 oe low phase", bus_data_oe, cur_it.oe);
      if (cur_it.oe) chk("R11 write data", bus_data_o, cur_it.dout);
      have = 0;
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", bus_addr, 0);
    chk("R1 rw", bus_rw, 1);
    chk("R1 oe", bus_data_oe, 0);
    chk("R1 eclk", eclk, 0);
    chk("R1 ready", acc_ready, 1);
    rst_n = 1;
    // first low phase shows zero visibility (R10)
    issue(1, 23'h012344, 1, 1, 0, 3'd5, 4'h3, 16'h0, 16'hA1B2); // R6 aligned word
    issue(1, 23'h000101, 1, 1, 0, 3'd2, 4'h7, 16'h0, 16'hC3D4); // R7 odd word
    issue(1, 23'h00ABC6, 0, 1, 0, 3'd1, 4'h9, 16'h0, 16'hE5FF); // R8 even byte
    issue(1, 23'h00ABC7, 0, 1, 0, 3'd6, 4'hA, 16'h0, 16'h9900); // R9 odd byte
    issue(1, 23'h7F0010, 1, 0, 1, 3'd4, 4'hF, 16'hBEEF, 16'h1234); // R11 write
    issue(1, 23'h400020, 1, 1, 1, 3'd3, 4'h1, 16'h0, 16'h5555);   // external read
    issue(0, 23'h0, 0, 1, 0, 3'd0, 4'h0, 16'h0, 16'h0);           // R2 idle
    issue(1, 23'h000F00, 1, 1, 0, 3'd7, 4'h2, 16'h0, 16'h0F0F);
    issue(1, 23'h000F01, 0, 0, 0, 3'd0, 4'h4, 16'h00AA, 16'h0);   // byte write
    issue(1, 23'h003333, 1, 1, 0, 3'd5, 4'h8, 16'h0, 16'h8181);
    issue(1, 23'h003334, 0, 1, 0, 3'd2, 4'hC, 16'h0, 16'h4200);
    issue(0, 23'h0, 0, 1, 0, 3'd0, 4'h0, 16'h0, 16'h0);
    issue(0, 23'h0, 0, 1, 0, 3'd0, 4'h0, 16'h0, 16'h0);
    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule